// File: doc/BRIEF.md
# Framebuffer Word Pixel Unpacker

This block sits between a framebuffer fetch engine and the colour pipeline of a display controller. It accepts one packed memory word at a time over a valid/ready handshake and emits the pixels held in that word, one per cycle, over a second valid/ready handshake. Pixels of 1, 2, 4 or 8 bits come out as a zero-extended palette index marked as indexed. Pixels of 12, 16 or 24 bits come out as a widened 24-bit RGB value. Memory access and palette lookup belong to neighbouring blocks.

The pixel depth comes from a 3-bit code. Two ordering flags select byte reversal of the word and pixel reversal inside each byte, and byte reversal wins when both are set. A red/blue swap flag applies to direct-colour pixels. The `EXTENDED` parameter selects one of two variants. In the base variant, an external 2-bit board mux select decides how 16-bit pixels are read. In the extended variant, the mux select is ignored and the depth code alone picks 5:5:5+I, 5:6:5 or 4:4:4. All configuration inputs are sampled in the cycle a word is accepted and held for every pixel of that word.

Top module: `pix_unpack`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A word is taken when `in_valid` and `in_ready` are both 1. `in_ready` is 1 when no word is held, or when the last pixel of the held word is being taken in that cycle. One pixel leaves per cycle with `out_ready` high. While `out_valid` is 1 and `out_ready` is 0, all pixel outputs hold steady and `in_ready` is 0.
- R3: Depth codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bits per pixel, so 32, 16, 8 and 4 pixels per 32-bit word. With no reordering, pixel k is taken from bits [k*b +: b]. These pixels come out with `out_indexed`=1, the bits zero-extended in `out_index`, and `out_rgb`=0.
- R4: The 5:5:5+I layout reads red from bits [4:0], green from [9:5] and blue from [14:10], and ignores bit 15. Each 5-bit field is shifted left by 3 with zero fill. Direct pixels drive `out_index`=0 and `out_indexed`=0, and `out_rgb` is {red, green, blue} with red in [23:16].
- R5: The 5:6:5 layout reads red from [4:0] (shifted left 3), green from [10:5] (shifted left 2) and blue from [15:11] (shifted left 3).
- R6: The 4:4:4 layout reads red from [3:0], green from [7:4] and blue from [11:8], each shifted left by 4. Bits [15:12] are ignored.
- R7: Depth code 5 gives one pixel per word, with red from [7:0], green from [15:8] and blue from [23:16]. Bits [31:24] are ignored.
- R8: When `cfg_swap_rb` is 1, the red and blue components of a direct-colour pixel are exchanged, except where R11 forces the swap.
- R9: When `cfg_byte_rev` is 1, the four bytes of the word are reversed (byte 0 with byte 3, byte 1 with byte 2) before pixels are taken LSB-first.
- R10: When `cfg_pix_rev` is 1 and `cfg_byte_rev` is 0, the order of sub-byte pixels inside each byte is reversed, so that the first pixel of a byte comes from its most significant bits. This has no effect at 8 bits per pixel or more. When both flags are 1, only the byte reversal applies.
- R11: In the base variant, depth codes 4, 6 and 7 all give 16-bit pixels, two per word, with `mux_sel` deciding the layout. A value of 1 gives 5:5:5+I. Values 0 and 2 give 5:6:5 with the swap flag honoured. A value of 3 gives 5:6:5 with red and blue always swapped.
- R12: In the extended variant, `mux_sel` is ignored. Code 4 gives 5:5:5+I, code 6 gives 5:6:5 and code 7 gives 4:4:4 (in a 16-bit container, two per word), all with the swap flag honoured.
- R13: Depth, swap, ordering and mux inputs are sampled when a word is accepted. Changing them later does not alter the pixels of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_word | input | WORD_W | Packed framebuffer word |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_swap_rb | input | 1 | Exchange red and blue |
| cfg_byte_rev | input | 1 | Reverse bytes of the word |
| cfg_pix_rev | input | 1 | Reverse sub-byte pixels within each byte |
| mux_sel | input | 2 | Board mux select for 16-bit pixels (base variant) |
| out_valid | output | 1 | Pixel present |
| out_ready | input | 1 | Pixel taken this cycle |
| out_indexed | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Zero-extended palette index |
| out_rgb | output | 24 | Direct-colour pixel, red in [23:16] |

## Verification
The assertions assume only that the sink may lower `out_ready` in any cycle. They check that a stalled pixel is held and that no word is taken during a stall. Configuration inputs need no stability assumption, because they are captured at acceptance, so the stimulus changes them freely on every cycle to exercise R13. The source keeps `in_valid` high with an unchanged word until it is taken. The stimulus covers all four mux values and every depth code. Both variants are driven from the same inputs and compared against one model.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    typedef enum logic [2:0] {
        FMT_IDX1    = 3'd0,
        FMT_IDX2    = 3'd1,
        FMT_IDX4    = 3'd2,
        FMT_IDX8    = 3'd3,
        FMT_RGB5551 = 3'd4,
        FMT_RGB565  = 3'd5,
        FMT_RGB444  = 3'd6,
        FMT_RGB888  = 3'd7
    } pix_fmt_e;

    // Storage stride of one pixel inside the word, in bits.
    function automatic int unsigned fmt_bits(input pix_fmt_e f);
        case (f)
            FMT_IDX1:   return 1;
            FMT_IDX2:   return 2;
            FMT_IDX4:   return 4;
            FMT_IDX8:   return 8;
            FMT_RGB888: return 32;
            default:    return 16;
        endcase
    endfunction

    // Map depth code and board mux onto an internal format.
    function automatic pix_fmt_e resolve_fmt(input logic [2:0] depth,
                                             input logic [1:0] mux,
                                             input logic       ext);
        case (depth)
            3'd0:    return FMT_IDX1;
            3'd1:    return FMT_IDX2;
            3'd2:    return FMT_IDX4;
            3'd3:    return FMT_IDX8;
            3'd5:    return FMT_RGB888;
            default: begin
                if (ext) begin
                    if (depth == 3'd6) return FMT_RGB565;
                    if (depth == 3'd7) return FMT_RGB444;
                    return FMT_RGB5551;
                end
                return (mux == 2'd1) ? FMT_RGB5551 : FMT_RGB565;
            end
        endcase
    endfunction

    // Board mux value 3 forces red/blue exchange on 16-bit pixels.
    function automatic logic resolve_swap(input logic [2:0] depth,
                                          input logic [1:0] mux,
                                          input logic       swap_rb,
                                          input logic       ext);
        if (!ext && (depth == 3'd4 || depth == 3'd6 || depth == 3'd7) && mux == 2'd3)
            return 1'b1;
        return swap_rb;
    endfunction

endpackage

// File: rtl/pix_unpack_order.sv
module pix_unpack_order
    import pix_unpack_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    input  pix_fmt_e          fmt_i,
    input  logic              byte_rev_i,
    input  logic              pix_rev_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] byte_swapped;
    logic [WORD_W-1:0] pix_swapped;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] src;
        logic [7:0] rev;

        assign src = word_i[b*8 +: 8];
        assign byte_swapped[b*8 +: 8] = word_i[(NBYTES-1-b)*8 +: 8];

        always_comb begin
            rev = src;
            case (fmt_i)
                FMT_IDX1: for (int i = 0; i < 8; i++) rev[i] = src[7-i];
                FMT_IDX2: rev = {src[1:0], src[3:2], src[5:4], src[7:6]};
                FMT_IDX4: rev = {src[3:0], src[7:4]};
                default:  rev = src;
            endcase
        end

        assign pix_swapped[b*8 +: 8] = rev;
    end

    // Byte reversal outranks pixel reversal.
    assign word_o = byte_rev_i ? byte_swapped :
                    pix_rev_i  ? pix_swapped  : word_i;

endmodule

// File: rtl/pix_unpack_color.sv
module pix_unpack_color
    import pix_unpack_pkg::*;
(
    input  pix_fmt_e    fmt_i,
    input  logic        swap_i,
    input  logic [23:0] raw_i,
    output logic        indexed_o,
    output logic [7:0]  index_o,
    output logic [23:0] rgb_o
);
    logic [7:0] red, grn, blu;

    always_comb begin
        indexed_o = 1'b0;
        index_o   = 8'h00;
        red       = 8'h00;
        grn       = 8'h00;
        blu       = 8'h00;
        case (fmt_i)
            FMT_IDX1: begin indexed_o = 1'b1; index_o = {7'b0, raw_i[0]};   end
            FMT_IDX2: begin indexed_o = 1'b1; index_o = {6'b0, raw_i[1:0]}; end
            FMT_IDX4: begin indexed_o = 1'b1; index_o = {4'b0, raw_i[3:0]}; end
            FMT_IDX8: begin indexed_o = 1'b1; index_o = raw_i[7:0];         end
            FMT_RGB5551: begin
                red = {raw_i[4:0],   3'b0};
                grn = {raw_i[9:5],   3'b0};
                blu = {raw_i[14:10], 3'b0};
            end
            FMT_RGB565: begin
                red = {raw_i[4:0],   3'b0};
                grn = {raw_i[10:5],  2'b0};
                blu = {raw_i[15:11], 3'b0};
            end
            FMT_RGB444: begin
                red = {raw_i[3:0],  4'b0};
                grn = {raw_i[7:4],  4'b0};
                blu = {raw_i[11:8], 4'b0};
            end
            default: begin
                red = raw_i[7:0];
                grn = raw_i[15:8];
                blu = raw_i[23:16];
            end
        endcase
        if (indexed_o)
            rgb_o = 24'h0;
        else if (swap_i)
            rgb_o = {blu, grn, red};
        else
            rgb_o = {red, grn, blu};
    end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter bit EXTENDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [2:0]        cfg_depth,
    input  logic              cfg_swap_rb,
    input  logic              cfg_byte_rev,
    input  logic              cfg_pix_rev,
    input  logic [1:0]        mux_sel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_indexed,
    output logic [7:0]        out_index,
    output logic [23:0]       out_rgb
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] word;
        pix_fmt_e          fmt;
        logic              swap;
        logic [CNT_W-1:0]  left;
    } state_t;

    state_t st_d, st_q;

    pix_fmt_e          fmt_acc;
    logic              swap_acc;
    logic [WORD_W-1:0] word_ord;
    logic              pop;
    logic              last;
    logic              accept;

    function automatic logic [CNT_W-1:0] last_slot(input pix_fmt_e f);
        if (f == FMT_RGB888) return '0;
        return CNT_W'(WORD_W / fmt_bits(f) - 1);
    endfunction

    assign fmt_acc  = resolve_fmt(cfg_depth, mux_sel, EXTENDED);
    assign swap_acc = resolve_swap(cfg_depth, mux_sel, cfg_swap_rb, EXTENDED);

    pix_unpack_order #(.WORD_W(WORD_W)) u_order (
        .word_i     (in_word),
        .fmt_i      (fmt_acc),
        .byte_rev_i (cfg_byte_rev),
        .pix_rev_i  (cfg_pix_rev),
        .word_o     (word_ord)
    );

    always_comb begin
        st_d     = st_q;
        pop      = st_q.busy && out_ready;
        last     = (st_q.left == '0);
        in_ready = !st_q.busy || (pop && last);
        accept   = in_valid && in_ready;

        if (pop) begin
            if (last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.word = st_q.word >> fmt_bits(st_q.fmt);
                st_d.left = st_q.left - 1'b1;
            end
        end

        if (accept) begin
            st_d.busy = 1'b1;
            st_d.word = word_ord;
            st_d.fmt  = fmt_acc;
            st_d.swap = swap_acc;
            st_d.left = last_slot(fmt_acc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.busy;

    pix_unpack_color u_color (
        .fmt_i     (st_q.fmt),
        .swap_i    (st_q.swap),
        .raw_i     (st_q.word[23:0]),
        .indexed_o (out_indexed),
        .index_o   (out_index),
        .rgb_o     (out_rgb)
    );

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_indexed,
    input logic [7:0]  out_index,
    input logic [23:0] out_rgb
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_indexed)
                                       && $stable(out_index) && $stable(out_rgb)));

    // R2
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R2
    accept_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R3
    index_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_indexed) |-> (out_rgb == 24'h0));

endmodule

bind pix_unpack pix_unpack_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_indexed (out_indexed),
    .out_index   (out_index),
    .out_rgb     (out_rgb)
);

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_word;
    logic [2:0]  cfg_depth;
    logic        cfg_swap_rb, cfg_byte_rev, cfg_pix_rev;
    logic [1:0]  mux_sel;
    logic        out_ready;

    logic        in_ready, out_valid, out_indexed;
    logic [7:0]  out_index;
    logic [23:0] out_rgb;
    logic        in_ready_x, out_valid_x, out_indexed_x;
    logic [7:0]  out_index_x;
    logic [23:0] out_rgb_x;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [31:0] qw [0:15];
    logic [7:0]  qc [0:15];
    int head = 0, tail = 0, qcnt = 0, kidx = 0;
    bit accepted;
    bit stall_prev = 0;
    logic [32:0] held;
    string tag_force = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_unpack #(.WORD_W(32), .EXTENDED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .cfg_depth(cfg_depth), .cfg_swap_rb(cfg_swap_rb),
        .cfg_byte_rev(cfg_byte_rev), .cfg_pix_rev(cfg_pix_rev), .mux_sel(mux_sel),
        .out_valid(out_valid), .out_ready(out_ready), .out_indexed(out_indexed),
        .out_index(out_index), .out_rgb(out_rgb));

    pix_unpack #(.WORD_W(32), .EXTENDED(1'b1)) u_dut_ext (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_x),
        .in_word(in_word), .cfg_depth(cfg_depth), .cfg_swap_rb(cfg_swap_rb),
        .cfg_byte_rev(cfg_byte_rev), .cfg_pix_rev(cfg_pix_rev), .mux_sel(mux_sel),
        .out_valid(out_valid_x), .out_ready(out_ready), .out_indexed(out_indexed_x),
        .out_index(out_index_x), .out_rgb(out_rgb_x));

    // cfg packing: {mux[1:0], pix_rev, byte_rev, swap, depth[2:0]}
    function automatic int ppw(input logic [7:0] c);
        if (c[2:0] < 3'd4) return 32 >> c[2:0];
        if (c[2:0] == 3'd5) return 1;
        return 2;
    endfunction

    function automatic logic [32:0] exp_pix(input logic [31:0] w, input logic [7:0] c,
                                            input int k, input bit ext);
        logic [31:0] w2, raw;
        int b, pos, per;
        logic [7:0] r, g, bl, t;
        bit sw;
        int lay;
        w2 = c[4] ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        b = (c[2:0] < 3'd4) ? (1 << c[2:0]) : (c[2:0] == 3'd5) ? 24 : 16;
        if (!c[4] && c[5] && b < 8) begin
            per = 8 / b;
            pos = (k / per) * 8 + (per - 1 - (k % per)) * b;
        end else begin
            pos = k * b;
        end
        raw = w2 >> pos;
        if (b <= 8) return {1'b1, 8'(raw & ((32'd1 << b) - 1)), 24'h0};
        sw = c[3];
        if (c[2:0] == 3'd5) lay = 3;
        else if (ext) lay = (c[2:0] == 3'd6) ? 1 : (c[2:0] == 3'd7) ? 2 : 0;
        else begin
            lay = (c[7:6] == 2'd1) ? 0 : 1;
            if (c[7:6] == 2'd3) sw = 1;
        end
        case (lay)
            0: begin r = {raw[4:0],3'b0}; g = {raw[9:5],3'b0};  bl = {raw[14:10],3'b0}; end
            1: begin r = {raw[4:0],3'b0}; g = {raw[10:5],2'b0}; bl = {raw[15:11],3'b0}; end
            2: begin r = {raw[3:0],4'b0}; g = {raw[7:4],4'b0};  bl = {raw[11:8],4'b0};  end
            default: begin r = raw[7:0]; g = raw[15:8]; bl = raw[23:16]; end
        endcase
        if (sw) begin t = r; r = bl; bl = t; end
        return {1'b0, 8'h00, r, g, bl};
    endfunction

    function automatic string tag_of(input logic [7:0] c, input bit ext);
        if (c[4]) return "R9";
        if (c[5] && c[2:0] < 3'd3) return "R10";
        if (c[2:0] < 3'd4) return "R3";
        if (c[2:0] == 3'd5) return c[3] ? "R8" : "R7";
        if (ext) return (c[2:0] == 3'd7) ? "R6" : (c[2:0] == 3'd6) ? "R5" : "R12";
        return (c[7:6] == 2'd1) ? "R4" : "R11";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle: set inputs just after a falling edge, observe handshakes, wait.
    task automatic tick(input logic v, input logic [31:0] w, input logic [7:0] c,
                        input logic rdy);
        string tg;
        in_valid = v; in_word = w; out_ready = rdy;
        cfg_depth = c[2:0]; cfg_swap_rb = c[3]; cfg_byte_rev = c[4];
        cfg_pix_rev = c[5]; mux_sel = c[7:6];
        #1;
        accepted = 0;
        // R2: both variants share handshake timing
        check("R2", "ready/valid match", {31'b0, in_ready_x, out_valid_x},
              {31'b0, in_ready, out_valid});
        if (stall_prev)
            check("R2", "stall hold", {out_indexed, out_index, out_rgb}, held);
        stall_prev = out_valid && !out_ready;
        held = {out_indexed, out_index, out_rgb};
        if (stall_prev)
            check("R2", "stall blocks input", {32'b0, in_ready}, 33'd0);
        if (out_valid && out_ready) begin
            if (qcnt == 0) begin
                check("R2", "pixel without word", 33'd1, 33'd0);
            end else begin
                tg = (tag_force != "") ? tag_force : tag_of(qc[head], 0);
                check(tg, "base pixel", {out_indexed, out_index, out_rgb},
                      exp_pix(qw[head], qc[head], kidx, 0));
                tg = (tag_force != "") ? tag_force : tag_of(qc[head], 1);
                check(tg, "ext pixel", {out_indexed_x, out_index_x, out_rgb_x},
                      exp_pix(qw[head], qc[head], kidx, 1));
                kidx++;
                if (kidx == ppw(qc[head])) begin
                    kidx = 0; head = (head + 1) % 16; qcnt--;
                end
            end
        end
        if (in_valid && in_ready) begin
            qw[tail] = w; qc[tail] = c; tail = (tail + 1) % 16; qcnt++;
            accepted = 1;
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w, input logic [7:0] c);
        do tick(1'b1, w, c, 1'b1); while (!accepted);
        while (qcnt != 0) tick(1'b0, 32'h0, c, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; in_valid = 0; in_word = 0; cfg_depth = 0; cfg_swap_rb = 0;
        cfg_byte_rev = 0; cfg_pix_rev = 0; mux_sel = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset outputs", {31'b0, out_valid, in_ready}, 33'd1);
        rst_n = 1;
        @(negedge clk);
        check("R1", "after release", {31'b0, out_valid, in_ready}, 33'd1);

        // Directed sweep of depths, orderings, swap and mux values
        for (int d = 0; d < 8; d++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 2; s++)
                    for (int m = 0; m < 4; m++)
                        send(32'h8421_C3A5 ^ (d * 32'h0101_0101),
                             {m[1:0], o[1], o[0], s[0], d[2:0]});

        // R13: change configuration while a captured word is still draining
        tag_force = "R13";
        do tick(1'b1, 32'hF0E1_D2C3, 8'h03, 1'b1); while (!accepted);
        while (qcnt != 0) tick(1'b0, 32'h0, 8'hFD, 1'b1);
        do tick(1'b1, 32'h1234_ABCD, 8'h0D, 1'b0); while (!accepted);
        for (int i = 0; i < 4; i++) tick(1'b0, 32'h0, 8'h30, 1'b0);
        while (qcnt != 0) tick(1'b0, 32'h0, 8'h30, 1'b1);
        tag_force = "";

        // Random traffic with backpressure
        begin
            logic [31:0] w;
            logic [7:0]  c;
            logic        v;
            w = $urandom; c = 8'($urandom); v = 0;
            for (int i = 0; i < 6000; i++) begin
                if (!v || accepted) begin
                    w = $urandom;
                    v = ($urandom % 10) < 7;
                end
                c = 8'($urandom);
                tick(v, w, c, ($urandom % 10) < 7);
                if (accepted) v = 0;
            end
            while (qcnt != 0) tick(1'b0, 32'h0, 8'($urandom), 1'b1);
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule